// File: doc/BRIEF.md
# Secondary Interrupt Controller with Direct Forwarding

This block gathers up to 32 level-sensitive interrupt request lines. Each line has an enable bit. When any line that is both high and enabled is asserted, the block raises one combined request, and that request leaves on upstream line 31. A second path can send a fixed window of source lines (21 through 30) straight to the upstream lines with the same numbers. Each line in that window is switched on or off by its own forwarding-enable bit.

Software reaches the block through an APB-style 32-bit register bus inside a 4 KB window. Registers are selected by word index, which is the byte address shifted right by two. Accesses need no wait states. Writes take effect at the clock edge that ends the access phase. Read data is valid during the access phase. Every upstream output is registered, so an output responds one clock after the input change or the register write that causes it.

Top module: `irq_sec_ctrl`

## Requirements
- R1: After reset, the enable mask, the forwarding-enable register and every upstream output are zero. Reads of word indices 0, 1, 2, 4 and 8 return zero while all sources are low.
- R2: A write to word index 2 (byte 0x08) ORs the written value into the enable mask. A write to word index 3 (byte 0x0C) clears every enable bit that is set in the written value.
- R3: Upstream line 31 is high exactly when the AND of the sampled source levels and the enable mask is nonzero. It responds one clock after the cause.
- R4: A write to word index 8 (byte 0x20) ORs in only bits 21 to 30 of the written value (value AND 0x7FE00000). A write to word index 9 (byte 0x24) clears any bit that is set in the written value.
- R5: For each i from 21 to 30, upstream line i equals source i when forwarding bit i is set, and is low otherwise. It responds one clock after the cause.
- R6: A nonzero write to word index 4 (byte 0x10) sets enable bit 0. A nonzero write to word index 5 (byte 0x14) clears enable bit 0. A zero write to either has no effect. A read of word index 4 returns source level 0 in bit 0 and zeros in all other bits.
- R7: Reading word index 0 returns levels AND enable. Word index 1 returns the raw levels. Word index 2 returns the enable mask. Word index 8 returns the forwarding-enable register.
- R8: Reads of word indices 3, 5, 9 and every unmapped index return zero. Writes to unmapped indices change nothing.
- R9: Upstream lines 0 to 20 are always low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | Bus write (1) or read (0) |
| paddr | input | 12 | Byte address within the window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid during a read access |
| irq_src | input | 32 | Level-sensitive source lines |
| irq_up | output | 32 | Upstream lines: 21..30 forwarded, 31 combined, others low |

## Verification
Source patterns are applied in three groups. A single enabled line distinguishes a correct masked OR from an unmasked one. Lines that are high but disabled show that the mask is applied. Alternating and walking patterns across bits 20 to 31 separate the forwarding window from its two neighbours and from the combined line. Writes of all ones to the forwarding-set register show that bits outside the window are dropped. Zero and nonzero writes to the software-interrupt words tell a value test apart from a plain strobe. A behavioural model of all register state predicts the upstream lines on every clock, so a response one cycle late or one cycle early shows as a mismatch.

// File: rtl/sic_pkg.sv
package sic_pkg;
  localparam int DW     = 32;
  localparam int WIDX_W = 10;

  typedef enum logic [WIDX_W-1:0] {
    W_MASKED = 10'd0,
    W_RAW    = 10'd1,
    W_EN_SET = 10'd2,
    W_EN_CLR = 10'd3,
    W_SW_SET = 10'd4,
    W_SW_CLR = 10'd5,
    W_FW_SET = 10'd8,
    W_FW_CLR = 10'd9
  } word_e;

  // contiguous ones from bit lo to bit hi
  function automatic logic [DW-1:0] span_mask(input int lo, input int hi);
    logic [DW-1:0] m;
    m = '0;
    for (int b = 0; b < DW; b++) m[b] = (b >= lo) && (b <= hi);
    return m;
  endfunction

  function automatic logic [DW-1:0] bits_set(input logic [DW-1:0] cur,
                                             input logic [DW-1:0] val,
                                             input logic [DW-1:0] keep);
    return cur | (val & keep);
  endfunction

  function automatic logic [DW-1:0] bits_clr(input logic [DW-1:0] cur,
                                             input logic [DW-1:0] val);
    return cur & ~val;
  endfunction

  // next value of the upstream lines
  function automatic logic [DW-1:0] route_next(input logic [DW-1:0] lvl,
                                               input logic [DW-1:0] en,
                                               input logic [DW-1:0] fw,
                                               input logic [DW-1:0] win,
                                               input int sum_line);
    logic [DW-1:0] r;
    r = lvl & fw & win;
    r[sum_line] = |(lvl & en);
    return r;
  endfunction
endpackage

// File: rtl/sic_regs.sv
module sic_regs
  import sic_pkg::*;
#(
  parameter int FW_LO = 21,
  parameter int FW_HI = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic              rd_stb,
  input  logic [WIDX_W-1:0] widx,
  input  logic [DW-1:0]     wdata,
  input  logic [DW-1:0]     lvl_in,
  output logic [DW-1:0]     rdata,
  output logic [DW-1:0]     en_q,
  output logic [DW-1:0]     fw_q,
  output logic [DW-1:0]     lvl_q,
  output logic [DW-1:0]     en_nxt,
  output logic [DW-1:0]     fw_nxt
);
  localparam logic [DW-1:0] FW_WIN = span_mask(FW_LO, FW_HI);

  logic wr_mapped;
  logic wr_nonzero;
  assign wr_nonzero = |wdata;

  always_comb begin
    en_nxt    = en_q;
    fw_nxt    = fw_q;
    wr_mapped = 1'b0;
    if (wr_stb) begin
      wr_mapped = 1'b1;
      case (widx)
        W_EN_SET: en_nxt = bits_set(en_q, wdata, '1);
        W_EN_CLR: en_nxt = bits_clr(en_q, wdata);
        W_SW_SET: if (wr_nonzero) en_nxt[0] = 1'b1;
        W_SW_CLR: if (wr_nonzero) en_nxt[0] = 1'b0;
        W_FW_SET: fw_nxt = bits_set(fw_q, wdata, FW_WIN);
        W_FW_CLR: fw_nxt = bits_clr(fw_q, wdata);
        default:  wr_mapped = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      fw_q  <= '0;
      lvl_q <= '0;
    end else begin
      en_q  <= en_nxt;
      fw_q  <= fw_nxt;
      lvl_q <= lvl_in;
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_stb) begin
      case (widx)
        W_MASKED: rdata = lvl_q & en_q;
        W_RAW:    rdata = lvl_q;
        W_EN_SET: rdata = en_q;
        W_SW_SET: rdata = {{(DW-1){1'b0}}, lvl_q[0]};
        W_FW_SET: rdata = fw_q;
        default:  rdata = '0;
      endcase
    end
  end

  AST_EN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && widx == W_EN_SET) |=> ((en_q & $past(wdata)) == $past(wdata))); // R2
  AST_EN_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && widx == W_EN_CLR) |=> ((en_q & $past(wdata)) == '0)); // R2
  AST_FW_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (fw_q & ~FW_WIN) == '0); // R4
  AST_SW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !wr_nonzero && (widx == W_SW_SET || widx == W_SW_CLR)) |=> $stable(en_q)); // R6
  AST_UNMAPPED_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !wr_mapped) |=> ($stable(en_q) && $stable(fw_q))); // R8
endmodule

// File: rtl/sic_route.sv
module sic_route
  import sic_pkg::*;
#(
  parameter int FW_LO    = 21,
  parameter int FW_HI    = 30,
  parameter int SUM_LINE = 31
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] lvl_in,
  input  logic [DW-1:0] en_nxt,
  input  logic [DW-1:0] fw_nxt,
  output logic [DW-1:0] up_q
);
  localparam logic [DW-1:0] FW_WIN    = span_mask(FW_LO, FW_HI);
  localparam logic [DW-1:0] LIVE_MASK = FW_WIN | (DW'(1) << SUM_LINE);

  logic [DW-1:0] up_nxt;
  assign up_nxt = route_next(lvl_in, en_nxt, fw_nxt, FW_WIN, SUM_LINE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) up_q <= '0;
    else        up_q <= up_nxt;
  end

  AST_QUIET_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q & ~LIVE_MASK) == '0); // R9
endmodule

// File: rtl/irq_sec_ctrl.sv
module irq_sec_ctrl
  import sic_pkg::*;
#(
  parameter int N_SRC    = 32,
  parameter int ADDR_W   = 12,
  parameter int FW_LO    = 21,
  parameter int FW_HI    = 30,
  parameter int SUM_LINE = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DW-1:0]     pwdata,
  output logic [DW-1:0]     prdata,
  input  logic [N_SRC-1:0]  irq_src,
  output logic [N_SRC-1:0]  irq_up
);
  localparam logic [DW-1:0] FW_WIN = span_mask(FW_LO, FW_HI);

  logic              wr_stb;
  logic              rd_stb;
  logic [WIDX_W-1:0] widx;
  logic [DW-1:0]     lvl_in;
  logic [DW-1:0]     en_q, fw_q, lvl_q, en_nxt, fw_nxt, up_w;
  logic              unused_byte_lanes;

  assign wr_stb            = psel & penable & pwrite;
  assign rd_stb            = psel & ~pwrite;
  assign widx              = paddr[ADDR_W-1:2];
  assign unused_byte_lanes = ^paddr[1:0];
  assign lvl_in            = DW'(irq_src);

  sic_regs #(.FW_LO(FW_LO), .FW_HI(FW_HI)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_stb (wr_stb),
    .rd_stb (rd_stb),
    .widx   (widx),
    .wdata  (pwdata),
    .lvl_in (lvl_in),
    .rdata  (prdata),
    .en_q   (en_q),
    .fw_q   (fw_q),
    .lvl_q  (lvl_q),
    .en_nxt (en_nxt),
    .fw_nxt (fw_nxt)
  );

  sic_route #(.FW_LO(FW_LO), .FW_HI(FW_HI), .SUM_LINE(SUM_LINE)) u_route (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_in (lvl_in),
    .en_nxt (en_nxt),
    .fw_nxt (fw_nxt),
    .up_q   (up_w)
  );

  assign irq_up = up_w[N_SRC-1:0];

  AST_SUM_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    up_w[SUM_LINE] == |(lvl_q & en_q)); // R3
  AST_FW_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (up_w & FW_WIN) == (lvl_q & fw_q)); // R5
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> (up_w == '0 && en_q == '0 && fw_q == '0)); // R1
endmodule

// File: tb/irq_sec_ctrl_tb.sv
module irq_sec_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic [31:0] irq_src = '0;
  logic [31:0] irq_up;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit run = 1'b0;

  // reference state
  logic [31:0] m_en = '0, m_fw = '0, m_lvl = '0;

  always #4 clk = ~clk;

  irq_sec_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .irq_src(irq_src), .irq_up(irq_up)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  function automatic logic [31:0] model_read(input int w);
    case (w)
      0: return m_lvl & m_en;
      1: return m_lvl;
      2: return m_en;
      4: return {31'd0, m_lvl[0]};
      8: return m_fw;
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic [31:0] model_up();
    logic [31:0] r = '0;
    for (int i = 21; i <= 30; i++) r[i] = m_lvl[i] && m_fw[i];
    r[31] = (m_lvl & m_en) != 0;
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en <= '0; m_fw <= '0; m_lvl <= '0;
    end else begin
      m_lvl <= irq_src;
      if (psel && penable && pwrite) begin
        case (int'(paddr >> 2))
          2: m_en <= m_en | pwdata;
          3: m_en <= m_en & ~pwdata;
          4: if (pwdata != 0) m_en <= m_en | 32'd1;
          5: if (pwdata != 0) m_en <= m_en & ~32'd1;
          8: m_fw <= m_fw | (pwdata & 32'h7FE0_0000);
          9: m_fw <= m_fw & ~pwdata;
          default: ;
        endcase
      end
    end
  end

  // compare every cycle (R3/R5/R9)
  always @(negedge clk) if (run) chk(irq_up, model_up(), "R3/R5/R9 upstream lines");

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected<=100000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic wr(input int w, input logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 1; penable = 0; paddr = 12'(w << 2); pwdata = d;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic rd(input int w, input string what);
    @(negedge clk); psel = 1; pwrite = 0; penable = 0; paddr = 12'(w << 2);
    @(negedge clk); penable = 1;
    #1 chk(prdata, model_read(w), what);
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic drive(input logic [31:0] v);
    @(negedge clk); irq_src = v;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(irq_up, 32'd0, "R1 outputs in reset");
    rst_n = 1;
    run = 1;
    rd(0, "R1 masked status"); rd(1, "R1 raw"); rd(2, "R1 enable");
    rd(4, "R1 soft read"); rd(8, "R1 forward enable");

    // R3 and R2: masking
    drive(32'h0000_0020);
    chk(irq_up, 32'd0, "R3 disabled source gives no summary");
    wr(2, 32'h0000_00F0);
    rd(2, "R2 enable after set");
    @(negedge clk); chk({31'd0, irq_up[31]}, 32'd1, "R3 single enabled line");
    rd(0, "R7 masked status"); rd(1, "R7 raw");
    wr(2, 32'h0001_0000);
    rd(2, "R2 set ORs in");
    wr(3, 32'h0000_0020);
    rd(2, "R2 clear removes bit");
    @(negedge clk); chk({31'd0, irq_up[31]}, 32'd0, "R3 summary drops after clear");
    drive(32'h0001_0040);
    chk({31'd0, irq_up[31]}, 32'd1, "R3 other enabled line");

    // R4 / R5 forwarding
    wr(8, 32'hFFFF_FFFF);
    rd(8, "R4 set limited to window");
    drive(32'hFFFF_FFFF);
    chk(irq_up, 32'hFFE0_0000, "R5/R9 all high");
    drive(32'h5550_0000);
    drive(32'hAAA0_0000);
    for (int i = 20; i < 32; i++) drive(32'd1 << i);
    wr(9, 32'h0555_5555);
    rd(8, "R4 clear any bit");
    drive(32'h7FE0_0000);
    chk(irq_up & 32'h7FE0_0000, 32'h7AA0_0000, "R5 partly forwarded");
    wr(9, 32'hFFFF_FFFF);
    rd(8, "R4 clear all");
    @(negedge clk); chk(irq_up & 32'h7FE0_0000, 32'd0, "R5 held low when off");

    // R6 soft interrupt
    wr(3, 32'hFFFF_FFFF);
    drive(32'h0000_0001);
    wr(4, 32'd0);
    rd(2, "R6 zero write no effect");
    wr(4, 32'h0000_0100);
    rd(2, "R6 nonzero sets bit0");
    rd(4, "R6 soft read raw bit0");
    wr(5, 32'd0);
    rd(2, "R6 zero clear no effect");
    wr(5, 32'd7);
    rd(2, "R6 nonzero clears bit0");

    // R8 unmapped / write-only
    wr(2, 32'h0F0F_0F0F); wr(8, 32'h7FE0_0000);
    wr(6, 32'hFFFF_FFFF); wr(7, 32'hFFFF_FFFF); wr(1023, 32'hFFFF_FFFF); wr(0, 32'hFFFF_FFFF);
    rd(2, "R8 enable unchanged"); rd(8, "R8 forward unchanged");
    rd(3, "R8 write-only 3"); rd(5, "R8 write-only 5"); rd(9, "R8 write-only 9");
    rd(6, "R8 unmapped 6"); rd(1023, "R8 unmapped top");
    drive(32'hFFFF_FFFF);
    chk(irq_up & 32'h001F_FFFF, 32'd0, "R9 low lines stay low");

    repeat (3) @(negedge clk);
    run = 0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule